// File: doc/BRIEF.md
# Scalar Double-Precision Compare-to-Flags Unit

This block takes two 128-bit register images and compares the IEEE 754 double-precision numbers held in their low 64 bits. It turns the outcome into a three-bit condition code made of zero, parity and carry bits. The code has a separate pattern for an unordered result. The overflow, adjust and sign flag outputs are held at zero. The downstream flags register samples all six flag bits whenever the flag-write enable is high.

The compare is ordered, so any NaN operand, quiet or signalling, raises an invalid-operation indication. A mask input decides what happens next. With the mask clear, the flag write is suppressed and the code bits read zero. With the mask set, the flags are written with the unordered code. Each request is one cycle wide and qualified by `in_valid`. The result appears on registered outputs one clock later, qualified by `out_valid`.

Top module: `dpcmp_flags_unit`

## Requirements
- R1: Only bits 63:0 of each operand take part in the compare; bits 127:64 have no effect on any output.
- R2: When either operand is a NaN (exponent all ones, fraction non-zero) and the flags are written, the code is zero=1, parity=1, carry=1.
- R3: When the first operand is greater than the second, the code is zero=0, parity=0, carry=0.
- R4: When the first operand is less than the second, the code is zero=0, parity=0, carry=1.
- R5: When the operands are numerically equal, the code is zero=1, parity=0, carry=0; positive zero and negative zero are equal.
- R6: The overflow, adjust and sign flag outputs are zero whenever the flag-write enable is high.
- R7: `out_invalid` is high in the result cycle if and only if either operand is a quiet or signalling NaN.
- R8: With `in_inv_mask` low and an invalid operation, `out_flag_we` stays low and the zero, parity and carry outputs are all zero.
- R9: With `in_inv_mask` high and an invalid operation, `out_flag_we` is high and the unordered code is written.
- R10: `out_valid` is high exactly one cycle after `in_valid` and low otherwise. `out_flag_we` is only high together with `out_valid`. Synchronous reset clears `out_valid`, `out_flag_we`, `out_invalid` and the code bits.
- R11: Infinities and denormals compare by exact value, with no flush to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for one compare |
| in_op_a | input | 128 | First operand register image |
| in_op_b | input | 128 | Second operand register image |
| in_inv_mask | input | 1 | High masks the invalid-operation exception |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_flag_we | output | 1 | Flags register write enable |
| out_zero | output | 1 | Zero flag of the code |
| out_parity | output | 1 | Parity flag of the code |
| out_carry | output | 1 | Carry flag of the code |
| out_overflow | output | 1 | Overflow flag, always zero |
| out_adjust | output | 1 | Adjust flag, always zero |
| out_sign | output | 1 | Sign flag, always zero |
| out_invalid | output | 1 | Invalid-operation indication |

## Verification
The compare is driven with several kinds of operand pair:
- Normal values of equal and opposite signs, which separate the greater, less and equal codes and test the sign-magnitude ordering of negative numbers.
- Signed zeros and pairs that differ only in their upper halves, which show whether zero handling and the bit 63:0 select are right.
- Infinities, the smallest denormals and the largest finite value, which show exact ordering at both ends of the range.
- Quiet and signalling NaNs in either slot, each with the mask clear and with it set, which separate the suppressed write from the masked unordered write.
- Back-to-back and isolated requests, which pin down the one-cycle result timing.

// File: rtl/dpcmp_pkg.sv
package dpcmp_pkg;

    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = FP_W - EXP_W - 1;
    localparam int MAG_W  = FP_W - 1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_snan;
        logic             is_zero;
        logic [MAG_W-1:0] mag;
    } fp_class_t;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic zf;
        logic pf;
        logic cf;
    } cond_code_t;

    function automatic cond_code_t rel_to_code(rel_e r);
        cond_code_t c;
        case (r)
            REL_GT:  c = '{zf: 1'b0, pf: 1'b0, cf: 1'b0};
            REL_LT:  c = '{zf: 1'b0, pf: 1'b0, cf: 1'b1};
            REL_EQ:  c = '{zf: 1'b1, pf: 1'b0, cf: 1'b0};
            default: c = '{zf: 1'b1, pf: 1'b1, cf: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dpcmp_classify.sv
module dpcmp_classify
    import dpcmp_pkg::*;
#(
    parameter int WORD_W = 128
) (
    input  logic [WORD_W-1:0] word_in,
    output fp_class_t         cls
);
    fp_word_t fw;
    logic     exp_ones;
    logic     frac_nz;

    always_comb begin
        fw          = fp_word_t'(word_in[FP_W-1:0]);
        exp_ones    = &fw.expo;
        frac_nz     = |fw.frac;
        cls.sign    = fw.sign;
        cls.is_nan  = exp_ones && frac_nz;
        cls.is_snan = exp_ones && frac_nz && !fw.frac[FRAC_W-1];
        cls.is_zero = (fw.expo == '0) && !frac_nz;
        cls.mag     = word_in[MAG_W-1:0];
    end

endmodule

// File: rtl/dpcmp_order.sv
module dpcmp_order
    import dpcmp_pkg::*;
(
    input  fp_class_t a_cls,
    input  fp_class_t b_cls,
    output rel_e      rel
);
    logic a_mag_gt;

    always_comb begin
        a_mag_gt = a_cls.mag > b_cls.mag;
        if (a_cls.is_nan || b_cls.is_nan) begin
            rel = REL_UN;
        end else if (a_cls.is_zero && b_cls.is_zero) begin
            rel = REL_EQ;
        end else if (a_cls.sign != b_cls.sign) begin
            rel = a_cls.sign ? REL_LT : REL_GT;
        end else if (a_cls.mag == b_cls.mag) begin
            rel = REL_EQ;
        end else begin
            rel = (a_mag_gt ^ a_cls.sign) ? REL_GT : REL_LT;
        end
    end

endmodule

// File: rtl/dpcmp_result_stage.sv
module dpcmp_result_stage
    import dpcmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  rel_e       rel,
    input  logic       inv_mask,
    output logic       res_valid,
    output logic       res_we,
    output logic       res_invalid,
    output cond_code_t res_code
);
    logic invalid_c;
    logic write_c;

    assign invalid_c = (rel == REL_UN);
    assign write_c   = !invalid_c || inv_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_we      <= 1'b0;
            res_invalid <= 1'b0;
            res_code    <= '0;
        end else begin
            res_valid   <= in_valid;
            res_we      <= in_valid && write_c;
            res_invalid <= in_valid && invalid_c;
            if (in_valid && write_c) begin
                res_code <= rel_to_code(rel);
            end else begin
                res_code <= '0;
            end
        end
    end

    // R10: result strobe follows request by one cycle
    p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);
    p_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);
    p_we_in_window_r10: assert property (@(posedge clk) disable iff (rst)
        res_we |-> res_valid);
    // R8: unmasked invalid suppresses the write
    p_unmasked_block_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rel == REL_UN && !inv_mask) |=> (!res_we && res_code == '0 && res_invalid));
    // R9: masked invalid writes the unordered code
    p_masked_write_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rel == REL_UN && inv_mask) |=> (res_we && res_code.zf && res_code.pf && res_code.cf));
    // R2: parity only appears within the unordered code
    p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
        res_code.pf |-> (res_code.zf && res_code.cf && res_invalid));

endmodule

// File: rtl/dpcmp_flags_unit.sv
module dpcmp_flags_unit
    import dpcmp_pkg::*;
#(
    parameter int WORD_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_op_a,
    input  logic [WORD_W-1:0] in_op_b,
    input  logic              in_inv_mask,
    output logic              out_valid,
    output logic              out_flag_we,
    output logic              out_zero,
    output logic              out_parity,
    output logic              out_carry,
    output logic              out_overflow,
    output logic              out_adjust,
    output logic              out_sign,
    output logic              out_invalid
);
    localparam int N_OPS = 2;

    logic [WORD_W-1:0] op_words [N_OPS];
    fp_class_t         op_cls   [N_OPS];
    rel_e              rel;
    cond_code_t        code;

    assign op_words[0] = in_op_a;
    assign op_words[1] = in_op_b;

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        dpcmp_classify #(.WORD_W(WORD_W)) u_cls (
            .word_in (op_words[i]),
            .cls     (op_cls[i])
        );
    end

    dpcmp_order u_order (
        .a_cls (op_cls[0]),
        .b_cls (op_cls[1]),
        .rel   (rel)
    );

    dpcmp_result_stage u_stage (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .rel         (rel),
        .inv_mask    (in_inv_mask),
        .res_valid   (out_valid),
        .res_we      (out_flag_we),
        .res_invalid (out_invalid),
        .res_code    (code)
    );

    assign out_zero     = code.zf;
    assign out_parity   = code.pf;
    assign out_carry    = code.cf;
    assign out_overflow = 1'b0;
    assign out_adjust   = 1'b0;
    assign out_sign     = 1'b0;

    // R7: invalid indication only appears in a result cycle
    p_invalid_in_window_r7: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> out_valid);

endmodule

// File: tb/sim_dpcmp_flags_unit.sv
module sim_dpcmp_flags_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_op_a;
    logic [127:0] in_op_b;
    logic         in_inv_mask;
    logic         out_valid, out_flag_we, out_zero, out_parity, out_carry;
    logic         out_overflow, out_adjust, out_sign, out_invalid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    localparam logic [63:0] P_ONE  = 64'h3FF0000000000000;
    localparam logic [63:0] P_TWO  = 64'h4000000000000000;
    localparam logic [63:0] N_ONE  = 64'hBFF0000000000000;
    localparam logic [63:0] N_TWO  = 64'hC000000000000000;
    localparam logic [63:0] P_ZERO = 64'h0000000000000000;
    localparam logic [63:0] N_ZERO = 64'h8000000000000000;
    localparam logic [63:0] P_INF  = 64'h7FF0000000000000;
    localparam logic [63:0] N_INF  = 64'hFFF0000000000000;
    localparam logic [63:0] Q_NAN  = 64'h7FF8000000000000;
    localparam logic [63:0] S_NAN  = 64'h7FF0000000000001;
    localparam logic [63:0] DEN_1  = 64'h0000000000000001;
    localparam logic [63:0] DEN_2  = 64'h0000000000000002;
    localparam logic [63:0] MAXN   = 64'h7FEFFFFFFFFFFFFF;

    always #4 clk = ~clk;

    dpcmp_flags_unit u0 (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_op_a      (in_op_a),
        .in_op_b      (in_op_b),
        .in_inv_mask  (in_inv_mask),
        .out_valid    (out_valid),
        .out_flag_we  (out_flag_we),
        .out_zero     (out_zero),
        .out_parity   (out_parity),
        .out_carry    (out_carry),
        .out_overflow (out_overflow),
        .out_adjust   (out_adjust),
        .out_sign     (out_sign),
        .out_invalid  (out_invalid)
    );

    function automatic bit is_nan64(logic [63:0] v);
        return (&v[62:52]) && (|v[51:0]);
    endfunction

    // expected {valid, we, zf, pf, cf, of, af, sf, invalid}
    function automatic logic [8:0] model(logic [63:0] a, logic [63:0] b, bit mask);
        bit un, we;
        logic [2:0] code;
        real ra, rb;
        un = is_nan64(a) || is_nan64(b);
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        if (un)           code = 3'b111;
        else if (ra > rb) code = 3'b000;
        else if (ra < rb) code = 3'b001;
        else              code = 3'b100;
        we = !un || mask;
        return {1'b1, we, (we ? code : 3'b000), 3'b000, un};
    endfunction

    function automatic logic [8:0] observed();
        return {out_valid, out_flag_we, out_zero, out_parity, out_carry,
                out_overflow, out_adjust, out_sign, out_invalid};
    endfunction

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (valid we zf pf cf of af sf inv)", req, act, exp);
        end
    endtask

    task automatic run_case(string req, logic [127:0] a, logic [127:0] b, bit mask);
        @(negedge clk);
        in_valid = 1'b1; in_op_a = a; in_op_b = b; in_inv_mask = mask;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, observed(), model(a[63:0], b[63:0], mask));
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b1; in_op_a = '0; in_op_b = {64'd0, Q_NAN}; in_inv_mask = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset", observed(), 9'b0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R10 idle", observed(), 9'b0);
    endtask

    task automatic t_ordering();
        run_case("R3 2>1",   {64'd0, P_TWO}, {64'd0, P_ONE}, 1'b0);
        run_case("R4 1<2",   {64'd0, P_ONE}, {64'd0, P_TWO}, 1'b0);
        run_case("R3 -1>-2", {64'd0, N_ONE}, {64'd0, N_TWO}, 1'b0);
        run_case("R4 -2<1",  {64'd0, N_TWO}, {64'd0, P_ONE}, 1'b0);
        run_case("R5 1==1",  {64'd0, P_ONE}, {64'd0, P_ONE}, 1'b0);
        run_case("R6 flags zero on write", {64'd0, N_ONE}, {64'd0, P_ZERO}, 1'b0);
    endtask

    task automatic t_zero_sign();
        run_case("R5 +0==-0", {64'd0, P_ZERO}, {64'd0, N_ZERO}, 1'b0);
        run_case("R5 -0==+0", {64'd0, N_ZERO}, {64'd0, P_ZERO}, 1'b0);
        run_case("R4 -0<den", {64'd0, N_ZERO}, {64'd0, DEN_1}, 1'b0);
    endtask

    task automatic t_upper_ignored();
        run_case("R1 upper differs eq", {64'hFFFFFFFFFFFFFFFF, P_ONE}, {64'h0, P_ONE}, 1'b0);
        run_case("R1 upper nan pattern", {Q_NAN, P_ONE}, {S_NAN, P_TWO}, 1'b0);
    endtask

    task automatic t_range_edges();
        run_case("R11 inf>max",   {64'd0, P_INF}, {64'd0, MAXN}, 1'b0);
        run_case("R11 -inf<-2",   {64'd0, N_INF}, {64'd0, N_TWO}, 1'b0);
        run_case("R11 inf==inf",  {64'd0, P_INF}, {64'd0, P_INF}, 1'b0);
        run_case("R11 den1<den2", {64'd0, DEN_1}, {64'd0, DEN_2}, 1'b0);
        run_case("R11 den>+0",    {64'd0, DEN_1}, {64'd0, P_ZERO}, 1'b0);
    endtask

    task automatic t_nan();
        run_case("R8 qnan a unmasked", {64'd0, Q_NAN}, {64'd0, P_ONE}, 1'b0);
        run_case("R8 snan b unmasked", {64'd0, P_ONE}, {64'd0, S_NAN}, 1'b0);
        run_case("R9 qnan b masked",   {64'd0, P_ONE}, {64'd0, Q_NAN}, 1'b1);
        run_case("R9 snan a masked",   {64'd0, S_NAN}, {64'd0, N_INF}, 1'b1);
        run_case("R2 both nan masked", {64'd0, Q_NAN}, {64'd0, S_NAN}, 1'b1);
        run_case("R7 mask no effect on order", {64'd0, P_TWO}, {64'd0, P_ONE}, 1'b1);
    endtask

    task automatic t_timing();
        @(negedge clk);
        in_valid = 1'b1; in_op_a = {64'd0, P_ONE}; in_op_b = {64'd0, P_TWO}; in_inv_mask = 1'b0;
        @(negedge clk);
        check("R10 first of pair", observed(), model(P_ONE, P_TWO, 1'b0));
        in_op_a = {64'd0, Q_NAN};
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 second of pair", observed(), model(Q_NAN, P_TWO, 1'b0));
        @(negedge clk);
        check("R10 drops after gap", observed(), 9'b0);
    endtask

    initial begin
        t_reset();
        t_ordering();
        t_zero_sign();
        t_upper_ignored();
        t_range_edges();
        t_nan();
        t_timing();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL R10 watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule